// File: doc/BRIEF.md
# Serial Slave Configuration Access Port

This block is a four-wire serial slave port that gives an external host access to two internal storage regions: a nonvolatile region, which can be written and read back, and a volatile configuration region, which can only be read back. The host lowers an active-low select line and clocks in a one-byte command followed by a 24-bit start address. The rest of the transfer is write data, which is streamed byte by byte into the nonvolatile region, or readback data, which is streamed out of the region that the command picks. The address advances by one after every byte.

The serial pins are brought into the system clock domain through synchronisers. The system clock must run at least four times faster than the serial clock. Both storage regions sit outside the block behind simple synchronous memory ports. While the block is selected, the serial output is driven only during the data phase of a readback that is allowed. In every other case the block keeps its output enable low, so the pad stays at high impedance. A configuration-done input and a static readback-enable input together decide whether readback is honoured once the chip is in user mode.

Top module: `cfg_spi_port`

## Requirements
- R1: While the synchronised select is high, `spi_miso_oe` is 0, and it falls no later than four system clocks after `spi_csn` rises. Out of reset, `spi_miso_oe`, `nv_we`, `nv_re` and `vol_re` are all 0.
- R2: After reset, no frame is decoded until `spi_csn` has been seen high and then driven low. A select line that is already low during reset starts nothing: there is no memory request and no output enable.
- R3: The serial format is mode 0, with the most significant bit first. Input is sampled on the rising edge of `spi_sck`. A frame begins with an 8-bit opcode, followed by a 24-bit start address.
- R4: An opcode with bit 7 = 0 is a write. Each complete byte that follows the header produces one `nv_we` pulse carrying that byte. The first byte goes to the start address, and each later byte goes to the next address up.
- R5: Raising `spi_csn` in the middle of a frame aborts the frame. A partially received data byte is not written, and a partial header causes no request. The next frame is decoded normally.
- R6: An opcode with bit 7 = 1 is a read. After the header, data bytes from the start address upward are shifted out on `spi_miso`, changing on the falling edge of `spi_sck`, most significant bit first. `spi_miso_oe` is 1 during this data phase.
- R7: In a read opcode, bit 0 = 1 selects the nonvolatile region (requests on `nv_re`, data from `nv_rdata`). Bit 0 = 0 selects the volatile region (requests on `vol_re`, data from `vol_rdata`).
- R8: When `cfg_done` = 1 and `rb_enable` = 0, a read command is ignored: no read request is issued and `spi_miso_oe` stays 0. With `cfg_done` = 0, or with `rb_enable` = 1, reads are honoured.
- R9: Memory requests are single-cycle pulses, and at most one of `nv_we`, `nv_re` and `vol_re` is high in any cycle. Read data is expected one clock after the request and held until the next request to the same region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host (asynchronous) |
| spi_csn | input | 1 | Active-low select from the host (asynchronous) |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for the `spi_miso` pad |
| cfg_done | input | 1 | High once configuration has finished (user mode) |
| rb_enable | input | 1 | Static permission for readback in user mode |
| mem_addr | output | 24 | Address shared by all memory requests |
| nv_we | output | 1 | Write strobe to the nonvolatile region |
| nv_wdata | output | 8 | Write data to the nonvolatile region |
| nv_re | output | 1 | Read strobe to the nonvolatile region |
| nv_rdata | input | 8 | Read data from the nonvolatile region |
| vol_re | output | 1 | Read strobe to the volatile region |
| vol_rdata | input | 8 | Read data from the volatile region |

## Verification
The bound assertions check the following on every cycle:
- The output enable is off while the synchronised select is high.
- Nothing moves before the port is armed.
- Memory requests never overlap.
- Writes come only out of a write frame.
- An ignored read stays silent.
- The output enable is on only during a readback.

Only the bench scenarios can show the serial content: the order of the header bits, the byte values returned from each region and the address stepping across bytes. They also show that an aborted byte leaves memory unchanged, and that a select held low through reset stays inert until a real falling edge.

// File: rtl/cfg_spi_pkg.sv
`timescale 1ns/1ps
package cfg_spi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_WRITE,
    ST_READ,
    ST_DROP
  } frame_st_e;

  localparam int OPC_W       = 8;
  localparam int OPC_RD_BIT  = 7;
  localparam int OPC_RGN_BIT = 0;
endpackage

// File: rtl/cfg_spi_sync.sv
`timescale 1ns/1ps
module cfg_spi_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  // Reset value 0: a select line reads as "low, not armed" until it is really seen high
  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= async_i;
      for (int s = 1; s < STAGES; s++) begin
        chain[s] <= chain[s-1];
      end
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/cfg_spi_frame.sv
`timescale 1ns/1ps
module cfg_spi_frame
  import cfg_spi_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csn_s,
  input  logic              sck_rise,
  input  logic              mosi_s,
  input  logic              done_i,
  input  logic              rb_en_i,
  output frame_st_e         state_o,
  output logic              armed_o,
  output logic              hdr_go_o,
  output logic              hdr_read_o,
  output logic              hdr_nv_o,
  output logic [ADDR_W-1:0] hdr_addr_o,
  output logic              region_nv_o,
  output logic              wr_stb_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int HDR_BITS = OPC_W + ADDR_W;
  localparam int CNT_W    = $clog2(HDR_BITS + 1);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(DATA_W - 1);

  frame_st_e            state;
  logic                 armed;
  logic [HDR_BITS-1:0]  sr;
  logic [HDR_BITS-1:0]  sr_next;
  logic [CNT_W-1:0]     cnt;
  logic                 hdr_last_bit;
  logic                 blocked;

  assign sr_next      = {sr[HDR_BITS-2:0], mosi_s};
  assign hdr_last_bit = (state == ST_HDR) && sck_rise && !csn_s && (cnt == HDR_LAST);
  assign blocked      = done_i && !rb_en_i;

  // Header decode is handed to the memory side in the same cycle so the first read has slack
  assign hdr_read_o = sr_next[HDR_BITS-1-(OPC_W-1-OPC_RD_BIT)];
  assign hdr_nv_o   = sr_next[HDR_BITS-OPC_W+OPC_RGN_BIT];
  assign hdr_addr_o = sr_next[ADDR_W-1:0];
  assign hdr_go_o   = hdr_last_bit && !(hdr_read_o && blocked);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      armed       <= 1'b0;
      sr          <= '0;
      cnt         <= '0;
      region_nv_o <= 1'b0;
      wr_stb_o    <= 1'b0;
      wr_data_o   <= '0;
    end else begin
      wr_stb_o <= 1'b0;
      if (csn_s) begin
        armed <= 1'b1;
        state <= ST_IDLE;
        cnt   <= '0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (armed) begin
              state <= ST_HDR;
              cnt   <= '0;
            end
          end
          ST_HDR: begin
            if (sck_rise) begin
              sr <= sr_next;
              if (cnt == HDR_LAST) begin
                cnt <= '0;
                if (hdr_read_o) begin
                  region_nv_o <= hdr_nv_o;
                  state       <= blocked ? ST_DROP : ST_READ;
                end else begin
                  state <= ST_WRITE;
                end
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_WRITE: begin
            if (sck_rise) begin
              sr <= sr_next;
              if (cnt == BYTE_LAST) begin
                cnt       <= '0;
                wr_stb_o  <= 1'b1;
                wr_data_o <= sr_next[DATA_W-1:0];
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign state_o = state;
  assign armed_o = armed;
endmodule

// File: rtl/cfg_spi_memif.sv
`timescale 1ns/1ps
module cfg_spi_memif #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hdr_go,
  input  logic              hdr_read,
  input  logic              hdr_nv,
  input  logic [ADDR_W-1:0] hdr_addr,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              next_rd,
  input  logic              region_nv,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              nv_we,
  output logic [DATA_W-1:0] nv_wdata,
  output logic              nv_re,
  output logic              vol_re
);
  logic [ADDR_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr      <= '0;
      mem_addr <= '0;
      nv_we    <= 1'b0;
      nv_wdata <= '0;
      nv_re    <= 1'b0;
      vol_re   <= 1'b0;
    end else begin
      nv_we  <= 1'b0;
      nv_re  <= 1'b0;
      vol_re <= 1'b0;
      if (hdr_go) begin
        if (hdr_read) begin
          mem_addr <= hdr_addr;
          nv_re    <= hdr_nv;
          vol_re   <= !hdr_nv;
          ptr      <= hdr_addr + ADDR_W'(1);
        end else begin
          ptr <= hdr_addr;
        end
      end else if (wr_stb) begin
        mem_addr <= ptr;
        nv_we    <= 1'b1;
        nv_wdata <= wr_data;
        ptr      <= ptr + ADDR_W'(1);
      end else if (next_rd) begin
        mem_addr <= ptr;
        nv_re    <= region_nv;
        vol_re   <= !region_nv;
        ptr      <= ptr + ADDR_W'(1);
      end
    end
  end
endmodule

// File: rtl/cfg_spi_tx.sv
`timescale 1ns/1ps
module cfg_spi_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csn_s,
  input  logic              sck_fall,
  input  logic              rd_active,
  input  logic              region_nv,
  input  logic [DATA_W-1:0] nv_rdata,
  input  logic [DATA_W-1:0] vol_rdata,
  output logic              miso,
  output logic              miso_oe,
  output logic              next_rd
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  logic [BIT_W-1:0]  bit_idx;
  logic [DATA_W-1:0] sr;
  logic [DATA_W-1:0] src;

  assign src = region_nv ? nv_rdata : vol_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_idx <= '0;
      sr      <= '0;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
      next_rd <= 1'b0;
    end else begin
      next_rd <= 1'b0;
      if (csn_s || !rd_active) begin
        bit_idx <= '0;
        miso    <= 1'b0;
        miso_oe <= 1'b0;
      end else if (sck_fall) begin
        miso_oe <= 1'b1;
        if (bit_idx == '0) begin
          // Byte boundary: take the fetched byte and prefetch the one after it
          miso    <= src[DATA_W-1];
          sr      <= {src[DATA_W-2:0], 1'b0};
          next_rd <= 1'b1;
        end else begin
          miso <= sr[DATA_W-1];
          sr   <= {sr[DATA_W-2:0], 1'b0};
        end
        bit_idx <= (bit_idx == BIT_LAST) ? '0 : bit_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_spi_port.sv
`timescale 1ns/1ps
module cfg_spi_port
  import cfg_spi_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_csn,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic              cfg_done,
  input  logic              rb_enable,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              nv_we,
  output logic [DATA_W-1:0] nv_wdata,
  output logic              nv_re,
  input  logic [DATA_W-1:0] nv_rdata,
  output logic              vol_re,
  input  logic [DATA_W-1:0] vol_rdata
);
  logic [2:0]        pins_s;
  logic              sck_s, csn_s, mosi_s, sck_d;
  logic              sck_rise, sck_fall;
  frame_st_e         state;
  logic              armed;
  logic              hdr_go, hdr_read, hdr_nv, region_nv;
  logic [ADDR_W-1:0] hdr_addr;
  logic              wr_stb, next_rd;
  logic [DATA_W-1:0] wr_data;

  cfg_spi_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .async_i({spi_sck, spi_csn, spi_mosi}),
    .sync_o (pins_s)
  );

  assign {sck_s, csn_s, mosi_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= sck_s;
  end

  assign sck_rise = sck_s && !sck_d;
  assign sck_fall = !sck_s && sck_d;

  cfg_spi_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .csn_s      (csn_s),
    .sck_rise   (sck_rise),
    .mosi_s     (mosi_s),
    .done_i     (cfg_done),
    .rb_en_i    (rb_enable),
    .state_o    (state),
    .armed_o    (armed),
    .hdr_go_o   (hdr_go),
    .hdr_read_o (hdr_read),
    .hdr_nv_o   (hdr_nv),
    .hdr_addr_o (hdr_addr),
    .region_nv_o(region_nv),
    .wr_stb_o   (wr_stb),
    .wr_data_o  (wr_data)
  );

  cfg_spi_memif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_memif (
    .clk      (clk),
    .rst      (rst),
    .hdr_go   (hdr_go),
    .hdr_read (hdr_read),
    .hdr_nv   (hdr_nv),
    .hdr_addr (hdr_addr),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .next_rd  (next_rd),
    .region_nv(region_nv),
    .mem_addr (mem_addr),
    .nv_we    (nv_we),
    .nv_wdata (nv_wdata),
    .nv_re    (nv_re),
    .vol_re   (vol_re)
  );

  cfg_spi_tx #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .csn_s    (csn_s),
    .sck_fall (sck_fall),
    .rd_active(state == ST_READ),
    .region_nv(region_nv),
    .nv_rdata (nv_rdata),
    .vol_rdata(vol_rdata),
    .miso     (spi_miso),
    .miso_oe  (spi_miso_oe),
    .next_rd  (next_rd)
  );
endmodule

// File: rtl/cfg_spi_port_chk.sv
`timescale 1ns/1ps
module cfg_spi_port_chk
  import cfg_spi_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      csn_s,
  input logic      armed,
  input frame_st_e state,
  input logic      miso_oe,
  input logic      nv_we,
  input logic      nv_re,
  input logic      vol_re
);
  p_oe_off_desel_r1: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> !miso_oe);

  p_inert_unarmed_r2: assert property (@(posedge clk) disable iff (rst)
    !armed |-> (state == ST_IDLE && !miso_oe && !nv_we && !nv_re && !vol_re));

  p_we_from_write_r4: assert property (@(posedge clk) disable iff (rst)
    nv_we |-> $past(state == ST_WRITE));

  p_oe_in_read_r6: assert property (@(posedge clk) disable iff (rst)
    miso_oe |-> state == ST_READ);

  p_drop_silent_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DROP) |-> (!miso_oe && !nv_re && !vol_re));

  p_one_request_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({nv_we, nv_re, vol_re}));
endmodule

bind cfg_spi_port cfg_spi_port_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .csn_s  (csn_s),
  .armed  (armed),
  .state  (state),
  .miso_oe(spi_miso_oe),
  .nv_we  (nv_we),
  .nv_re  (nv_re),
  .vol_re (vol_re)
);

// File: tb/cfg_spi_port_bench.sv
`timescale 1ns/1ps
module cfg_spi_port_bench;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 8;
  localparam int HALF   = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sck = 1'b0, spi_csn = 1'b0, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe;
  logic cfg_done = 1'b0, rb_enable = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic nv_we, nv_re, vol_re;
  logic [DATA_W-1:0] nv_wdata;
  logic [DATA_W-1:0] nv_rdata, vol_rdata;

  int checks = 0, errors = 0;
  int rd_cnt, wr_cnt;
  bit finished = 1'b0;
  bit oe_seen;

  logic [7:0] nvmem  [256];
  logic [7:0] volmem [256];

  always #10 clk = ~clk;

  cfg_spi_port u_cfg_spi_port (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_csn(spi_csn), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe), .cfg_done(cfg_done),
    .rb_enable(rb_enable), .mem_addr(mem_addr), .nv_we(nv_we), .nv_wdata(nv_wdata),
    .nv_re(nv_re), .nv_rdata(nv_rdata), .vol_re(vol_re), .vol_rdata(vol_rdata)
  );

  function automatic logic [7:0] init_val(input logic nv, input int a);
    return nv ? (8'(a) ^ 8'hA5) : 8'(a * 3 + 1);
  endfunction

  // Memory models: one-cycle read latency, data held until the next request
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) begin
        nvmem[i]  <= init_val(1'b1, i);
        volmem[i] <= init_val(1'b0, i);
      end
      nv_rdata  <= '0;
      vol_rdata <= '0;
      rd_cnt    <= 0;
      wr_cnt    <= 0;
    end else begin
      if (nv_we) begin
        nvmem[mem_addr[7:0]] <= nv_wdata;
        wr_cnt <= wr_cnt + 1;
      end
      if (nv_re)  nv_rdata  <= nvmem[mem_addr[7:0]];
      if (vol_re) vol_rdata <= volmem[mem_addr[7:0]];
      rd_cnt <= rd_cnt + int'(nv_re) + int'(vol_re);
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = tx[7-i];
      #(HALF);
      rx[7-i] = spi_miso;
      if (spi_miso_oe) oe_seen = 1'b1;
      spi_sck = 1'b1;
      #(HALF);
      spi_sck = 1'b0;
    end
  endtask

  task automatic spi_start();
    oe_seen = 1'b0;
    spi_csn = 1'b0;
    #(HALF);
  endtask

  task automatic spi_stop();
    #(HALF);
    spi_csn = 1'b1;
    #(4*HALF);
  endtask

  task automatic send_hdr(input logic [7:0] op, input logic [7:0] a);
    logic [7:0] d;
    spi_bits(op, 8, d);
    spi_bits(8'h00, 8, d);
    spi_bits(8'h00, 8, d);
    spi_bits(a, 8, d);
  endtask

  task automatic read_frame(input logic [7:0] op, input logic [7:0] a,
                            output logic [7:0] b0, output logic [7:0] b1);
    spi_start();
    send_hdr(op, a);
    spi_bits(8'h00, 8, b0);
    spi_bits(8'h00, 8, b1);
    spi_stop();
  endtask

  // {opcode, addr, done, enable, expect_oe, expect_first_byte}
  localparam logic [26:0] VEC [6] = '{
    {8'h81, 8'h0A, 1'b0, 1'b0, 1'b1, 8'hAF},
    {8'h80, 8'h0A, 1'b0, 1'b0, 1'b1, 8'h1F},
    {8'h81, 8'hFF, 1'b1, 1'b1, 1'b1, 8'h5A},
    {8'h80, 8'h40, 1'b1, 1'b0, 1'b0, 8'h00},
    {8'h80, 8'h7F, 1'b0, 1'b1, 1'b1, 8'h7E},
    {8'h81, 8'h33, 1'b1, 1'b0, 1'b0, 8'h00}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b0, b1, d;
    int r0, w0;
    repeat (5) @(posedge clk);
    #3;
    rst = 1'b0;
    #(2*HALF);
    check("R1 reset oe", 32'(spi_miso_oe), 32'd0);
    check("R9 reset strobes", {29'd0, nv_we, nv_re, vol_re}, 32'd0);

    // R2: select low through reset and never raised: frame must be inert
    oe_seen = 1'b0;
    send_hdr(8'h81, 8'h10);
    spi_bits(8'h00, 8, d);
    check("R2 no oe before arm", 32'(oe_seen), 32'd0);
    check("R2 no request before arm", 32'(rd_cnt + wr_cnt), 32'd0);
    spi_csn = 1'b1;
    #(4*HALF);

    // Table walk: R3 header, R6 streaming, R7 region select, R8 gating
    foreach (VEC[k]) begin
      logic [7:0] op, a, exp0;
      logic dn, en, exp_oe;
      {op, a, dn, en, exp_oe, exp0} = VEC[k];
      cfg_done  = dn;
      rb_enable = en;
      r0 = rd_cnt;
      read_frame(op, a, b0, b1);
      check("R8 readback oe gating", 32'(oe_seen), 32'(exp_oe));
      if (exp_oe) begin
        check("R7 R3 first byte", 32'(b0), 32'(exp0));
        check("R6 second byte", 32'(b1), 32'(init_val(op[0], int'(a) + 1)));
      end else begin
        check("R8 ignored read issues no request", 32'(rd_cnt - r0), 32'd0);
      end
      check("R1 oe off after deselect", 32'(spi_miso_oe), 32'd0);
    end
    cfg_done  = 1'b0;
    rb_enable = 1'b0;

    // R4: three-byte write then readback
    w0 = wr_cnt;
    spi_start();
    send_hdr(8'h01, 8'h20);
    spi_bits(8'h11, 8, d);
    spi_bits(8'h22, 8, d);
    spi_bits(8'h33, 8, d);
    spi_stop();
    check("R4 write count", 32'(wr_cnt - w0), 32'd3);
    check("R4 write drives no oe", 32'(oe_seen), 32'd0);
    read_frame(8'h81, 8'h20, b0, b1);
    check("R4 byte at start addr", 32'(b0), 32'h11);
    check("R4 byte at next addr", 32'(b1), 32'h22);
    read_frame(8'h81, 8'h22, b0, b1);
    check("R4 third byte", 32'(b0), 32'h33);
    check("R4 past end untouched", 32'(b1), 32'h86);

    // R5: abort during second data byte
    w0 = wr_cnt;
    spi_start();
    send_hdr(8'h01, 8'h30);
    spi_bits(8'h44, 8, d);
    spi_bits(8'h55, 5, d);
    spi_stop();
    check("R5 partial byte not written", 32'(wr_cnt - w0), 32'd1);
    read_frame(8'h81, 8'h30, b0, b1);
    check("R5 full byte written", 32'(b0), 32'h44);
    check("R5 aborted address unchanged", 32'(b1), 32'h94);

    // R5: abort inside header
    r0 = rd_cnt;
    w0 = wr_cnt;
    spi_start();
    spi_bits(8'h81, 8, d);
    spi_bits(8'h00, 4, d);
    spi_stop();
    check("R5 header abort no request", 32'((rd_cnt - r0) + (wr_cnt - w0)), 32'd0);
    check("R5 header abort no oe", 32'(oe_seen), 32'd0);
    read_frame(8'h80, 8'h05, b0, b1);
    check("R5 frame after abort byte0", 32'(b0), 32'h10);
    check("R5 frame after abort byte1", 32'(b1), 32'h13);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule